// File: doc/BRIEF.md
# Iterative Floating-Point Partial Remainder Unit

This unit divides one 80-bit extended-format value by another and returns the exact remainder. An operand is a sign bit, a 15-bit biased exponent and a 64-bit significand whose integer bit is explicit. The divisor is supplied as a magnitude only, because its sign never changes the result. The division is a sequential restoring long division. Each clock cycle produces one quotient bit. The remainder carries the dividend's sign and is renormalised before it is presented.

A caller pulses `start` while the unit is idle. The unit raises `busy` for the run and pulses `done` for one cycle when the results are ready. The results then hold until the next accepted start. The amount of reduction is bounded. When the dividend's exponent is 64 or more above the divisor's, a single call removes only 31 binary orders of magnitude and sets `c2`. The caller feeds the partial remainder back in until `c2` comes back clear. Operands must be finite normal numbers. Zeros, infinities, NaNs, denormals, and results whose exponent would fall to zero or below give unspecified results.

Top module: `fprem_unit`

## Requirements
- R1: `start` is accepted only when `busy` is low. `busy` is high from the cycle after acceptance until the cycle in which `done` is high, and it is low during that cycle. A `start` seen while `busy` is high is ignored: it changes no result and produces no extra `done`.
- R2: `done` is high for exactly one cycle per accepted start. `rem_sign`, `rem_exp`, `rem_man`, `c2` and `q_lo` keep their values from that cycle until the next start is accepted.
- R3: Let g be the dividend exponent minus the divisor exponent, and let n = g+1 for 0 <= g < 64, n = 32 for g >= 64, and n = 0 for g < 0. Then `done` is high exactly n+1 clock edges after the edge that samples `start`.
- R4: For 0 <= g < 64, the unit forms the truncated integer quotient Q of |a|/|b|. The remainder magnitude equals |a| - Q*|b| exactly and is below |b|, and `c2` = 0.
- R5: For g >= 64, the unit forms the truncated quotient Q of |a| / (|b| * 2^(g-31)). The remainder magnitude equals |a| - Q*|b|*2^(g-31), and `c2` = 1.
- R6: For g < 0, the result is the dividend unchanged, with Q = 0 and `c2` = 0.
- R7: `rem_sign` equals the dividend sign.
- R8: A nonzero remainder is output with significand bit 63 set. Its exponent is its weight expressed in the same bias as the inputs.
- R9: An exactly zero remainder is output with `rem_exp` = 0 and `rem_man` = 0.
- R10: `q_lo[0]`, `q_lo[1]` and `q_lo[2]` are bits 0, 1 and 2 of Q, with Q = 0 in the R6 case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a reduction with the presented operands |
| a_sign | input | 1 | Dividend sign |
| a_exp | input | 15 | Dividend biased exponent |
| a_man | input | 64 | Dividend significand, explicit integer bit |
| b_exp | input | 15 | Divisor biased exponent |
| b_man | input | 64 | Divisor significand, explicit integer bit |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle result strobe |
| rem_sign | output | 1 | Remainder sign |
| rem_exp | output | 15 | Remainder biased exponent |
| rem_man | output | 64 | Remainder significand |
| c2 | output | 1 | Reduction incomplete |
| q_lo | output | 3 | Low three quotient bits |

## Verification
The bench builds the unit with its default parameters: a 15-bit exponent, a 64-bit significand, a full-reduction limit of 64 and a 32-step partial pass. These values reach both sides of the 64 boundary (gaps of 63 and 64) and the shortest runs (a gap of zero and a negative gap). The reference model divides on 192-bit integers, so it reaches the full 128-bit scaled dividend at a gap of 63. Random gaps from -4 to 75, with mixed signs, exercise the latency formula and the renormalisation shift over the whole range of remainder sizes.

// File: rtl/fprem_pkg.sv
package fprem_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_NORM = 2'd2
  } fprem_state_e;
endpackage

// File: rtl/fprem_ctrl.sv
module fprem_ctrl
  import fprem_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] iters,
  output logic             load,
  output logic             step,
  output logic             last,
  output logic             finish,
  output logic             busy,
  output logic             done
);
  fprem_state_e st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic cnt_en;

  assign load   = (st_q == ST_IDLE) && start;
  assign step   = (st_q == ST_RUN);
  assign last   = step && (cnt_q == CNT_W'(1));
  assign finish = (st_q == ST_NORM);
  assign busy   = (st_q != ST_IDLE);
  assign cnt_en = load || step;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    case (st_q)
      ST_IDLE: if (start) begin
        cnt_n = iters;
        st_n  = (iters == '0) ? ST_NORM : ST_RUN;
      end
      ST_RUN: begin
        cnt_n = cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) st_n = ST_NORM;
      end
      ST_NORM: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      st_q <= st_n;
      done <= finish;
      if (cnt_en) cnt_q <= cnt_n;
    end
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_count_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cnt_q != '0));
endmodule

// File: rtl/fprem_divstep.sv
module fprem_divstep #(
  parameter int MAN_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             last,
  input  logic [MAN_W-1:0] ld_man,
  input  logic [MAN_W-1:0] dvs_man,
  output logic [MAN_W-1:0] rem,
  output logic [2:0]       qbits
);
  logic [MAN_W:0]   r_q, r_n, diff;
  logic [MAN_W-1:0] d_q;
  logic [2:0]       q_q, q_n;
  logic             ge, upd;

  assign upd = load || step;

  always_comb begin
    ge   = (r_q >= {1'b0, d_q});
    diff = ge ? (r_q - {1'b0, d_q}) : r_q;
    if (load) begin
      r_n = {1'b0, ld_man};
      q_n = 3'b000;
    end else begin
      r_n = last ? diff : (diff << 1);
      q_n = {q_q[1:0], ge};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q <= '0;
      d_q <= '0;
      q_q <= '0;
    end else begin
      if (upd)  r_q <= r_n;
      if (upd)  q_q <= q_n;
      if (load) d_q <= dvs_man;
    end
  end

  assign rem   = r_q[MAN_W-1:0];
  assign qbits = q_q;

  // partial remainder stays below twice the divisor before each subtract
  assert_rem_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (r_q < {d_q, 1'b0}));
  assert_rem_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> (r_q[MAN_W] == 1'b0));
endmodule

// File: rtl/fprem_norm.sv
module fprem_norm #(
  parameter int MAN_W = 64,
  parameter int EXP_W = 15,
  parameter int XW    = EXP_W + 2
) (
  input  logic [MAN_W-1:0] man_in,
  input  logic [XW-1:0]    base_exp,
  output logic [MAN_W-1:0] man_out,
  output logic [EXP_W-1:0] exp_out
);
  localparam int LZ_W = $clog2(MAN_W + 1);
  logic [LZ_W-1:0] lz;
  logic            found;
  logic [XW-1:0]   e_full;

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = MAN_W - 1; i >= 0; i--) begin
      if (!found) begin
        if (man_in[i]) found = 1'b1;
        else           lz = lz + LZ_W'(1);
      end
    end
    e_full  = base_exp - {{(XW-LZ_W){1'b0}}, lz};
    man_out = man_in << lz;
    exp_out = found ? e_full[EXP_W-1:0] : '0;
  end
endmodule

// File: rtl/fprem_unit.sv
module fprem_unit #(
  parameter int EXP_W      = 15,
  parameter int MAN_W      = 64,
  parameter int FULL_GAP   = 64,
  parameter int PART_STEPS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             a_sign,
  input  logic [EXP_W-1:0] a_exp,
  input  logic [MAN_W-1:0] a_man,
  input  logic [EXP_W-1:0] b_exp,
  input  logic [MAN_W-1:0] b_man,
  output logic             busy,
  output logic             done,
  output logic             rem_sign,
  output logic [EXP_W-1:0] rem_exp,
  output logic [MAN_W-1:0] rem_man,
  output logic             c2,
  output logic [2:0]       q_lo
);
  localparam int XW    = EXP_W + 2;
  localparam int CNT_W = $clog2(FULL_GAP + 1);
  localparam logic signed [XW-1:0] GAP_LIM  = XW'(FULL_GAP);
  localparam logic        [XW-1:0] PART_OFS = XW'(PART_STEPS - 1);

  logic signed [XW-1:0] gap;
  logic                 g_neg, g_part;
  logic [CNT_W-1:0]     iters;
  logic [XW-1:0]        base_n, base_q;
  logic                 sign_q, part_q;
  logic                 load, step, last, finish;
  logic [MAN_W-1:0]     rem_raw, man_nrm;
  logic [EXP_W-1:0]     exp_nrm;
  logic [2:0]           qbits;

  always_comb begin
    gap    = signed'({2'b00, a_exp}) - signed'({2'b00, b_exp});
    g_neg  = gap < 0;
    g_part = gap >= GAP_LIM;
    if (g_neg) begin
      iters  = '0;
      base_n = {2'b00, a_exp};
    end else if (g_part) begin
      iters  = CNT_W'(PART_STEPS);
      base_n = {2'b00, a_exp} - PART_OFS;
    end else begin
      iters  = CNT_W'(gap + 1);
      base_n = {2'b00, b_exp};
    end
  end

  fprem_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .iters(iters),
    .load(load), .step(step), .last(last), .finish(finish),
    .busy(busy), .done(done)
  );

  fprem_divstep #(.MAN_W(MAN_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .last(last),
    .ld_man(a_man), .dvs_man(b_man), .rem(rem_raw), .qbits(qbits)
  );

  fprem_norm #(.MAN_W(MAN_W), .EXP_W(EXP_W), .XW(XW)) u_norm (
    .man_in(rem_raw), .base_exp(base_q), .man_out(man_nrm), .exp_out(exp_nrm)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      sign_q   <= 1'b0;
      part_q   <= 1'b0;
      rem_sign <= 1'b0;
      rem_exp  <= '0;
      rem_man  <= '0;
      c2       <= 1'b0;
      q_lo     <= '0;
    end else begin
      if (load) begin
        base_q <= base_n;
        sign_q <= a_sign;
        part_q <= g_part;
      end
      if (finish) begin
        rem_sign <= sign_q;
        rem_exp  <= exp_nrm;
        rem_man  <= man_nrm;
        c2       <= part_q;
        q_lo     <= qbits;
      end
    end
  end

  assert_norm_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (rem_man != '0)) |-> rem_man[MAN_W-1]);
  assert_zero_exp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (rem_man == '0)) |-> (rem_exp == '0));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> ($stable(rem_man) && $stable(rem_exp)
                                 && $stable(c2) && $stable(q_lo) && $stable(rem_sign)));
  assert_c2_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !c2 && (rem_man != '0)) |-> (rem_exp != '0));
endmodule

// File: tb/sim_fprem_unit.sv
module sim_fprem_unit;
  localparam int CLK_P = 10;
  localparam int BIAS  = 16383;

  typedef struct {
    string       tag;
    int          lat;
    longint      t0;
    logic        sign;
    logic [14:0] exp;
    logic [63:0] man;
    logic        c2;
    logic [2:0]  q;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, a_sign = 1'b0;
  logic [14:0] a_exp = '0, b_exp = '0;
  logic [63:0] a_man = '0, b_man = '0;
  logic busy, done, rem_sign, c2;
  logic [14:0] rem_exp;
  logic [63:0] rem_man;
  logic [2:0] q_lo;

  int n_chk = 0, n_bad = 0;
  longint cyc = 0;
  exp_t sb[$];
  exp_t last_e;
  logic [63:0] rs = 64'h9E3779B97F4A7C15;

  fprem_unit #(.EXP_W(15), .MAN_W(64), .FULL_GAP(64), .PART_STEPS(32)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .a_sign(a_sign), .a_exp(a_exp),
    .a_man(a_man), .b_exp(b_exp), .b_man(b_man), .busy(busy), .done(done),
    .rem_sign(rem_sign), .rem_exp(rem_exp), .rem_man(rem_man), .c2(c2), .q_lo(q_lo)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [79:0] act, logic [79:0] ex);
    n_chk++;
    if (act !== ex) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, ex);
    end
  endtask

  function automatic logic [63:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    return rs;
  endfunction

  function automatic exp_t model(logic sa, logic [14:0] ea, logic [63:0] ma,
                                 logic [14:0] eb, logic [63:0] mb);
    exp_t e;
    int g, base, sh;
    logic [191:0] num, qq, rr;
    logic [63:0] r;
    g = int'(ea) - int'(eb);
    e.c2 = 1'b0;
    if (g < 0) begin
      e.tag = "R6"; e.lat = 1; r = ma; qq = '0; base = int'(ea);
    end else if (g < 64) begin
      e.tag = "R4"; e.lat = g + 2; num = {128'd0, ma} << g;
      qq = num / {128'd0, mb}; rr = num % {128'd0, mb}; r = rr[63:0]; base = int'(eb);
    end else begin
      e.tag = "R5"; e.lat = 33; e.c2 = 1'b1; num = {128'd0, ma} << 31;
      qq = num / {128'd0, mb}; rr = num % {128'd0, mb}; r = rr[63:0]; base = int'(ea) - 31;
    end
    e.q = qq[2:0];
    e.sign = sa;
    if (r == 0) begin
      e.exp = '0; e.man = '0;
    end else begin
      sh = 0;
      while (!r[63]) begin r = r << 1; sh++; end
      e.exp = 15'(base - sh); e.man = r;
    end
    e.t0 = 0;
    return e;
  endfunction

  task automatic drive(logic sa, logic [14:0] ea, logic [63:0] ma,
                       logic [14:0] eb, logic [63:0] mb, bit wait_done = 1);
    exp_t e;
    while (busy) @(negedge clk);
    e = model(sa, ea, ma, eb, mb);
    a_sign = sa; a_exp = ea; a_man = ma; b_exp = eb; b_man = mb;
    start = 1'b1; e.t0 = cyc;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
    if (wait_done) begin
      while (!done) @(negedge clk);
      @(negedge clk);
    end
  endtask

  // monitor: pops the scoreboard on every result strobe
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) chk("R2 done width", 80'(1), 80'(0));
      if (done) begin
        if (sb.size() == 0) begin
          chk("R1 unexpected done", 80'(1), 80'(0));
        end else begin
          exp_t e;
          e = sb.pop_front();
          last_e = e;
          chk("R3 latency", 80'(cyc - e.t0 - 1), 80'(e.lat));
          chk("R1 busy low at done", 80'(busy), 80'(0));
          chk({e.tag, " rem_man"}, 80'(rem_man), 80'(e.man));
          chk(e.man == 0 ? "R9 rem_exp" : "R8 rem_exp", 80'(rem_exp), 80'(e.exp));
          chk("R7 rem_sign", 80'(rem_sign), 80'(e.sign));
          chk({e.tag, " c2"}, 80'(c2), 80'(e.c2));
          chk("R10 q_lo", 80'(q_lo), 80'(e.q));
        end
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", 80'(busy), 80'(0));
    chk("R2 reset done", 80'(done), 80'(0));
    rst_n = 1'b1;
    @(negedge clk);
    // R4: 7 rem 2 = 1, quotient 3
    drive(1'b0, 15'(BIAS+2), 64'hE000_0000_0000_0000, 15'(BIAS+1), 64'h8000_0000_0000_0000);
    // R9: equal operands leave exact zero, quotient 1
    drive(1'b1, 15'(BIAS+5), 64'hC123_4567_89AB_CDEF, 15'(BIAS+5), 64'hC123_4567_89AB_CDEF);
    // R6: dividend exponent below divisor
    drive(1'b1, 15'(BIAS-3), 64'hA5A5_0000_1234_5678, 15'(BIAS), 64'h8000_0000_0000_0001);
    // R4 gap 0, dividend significand smaller
    drive(1'b0, 15'(BIAS), 64'h8000_0000_0000_0000, 15'(BIAS), 64'hFFFF_FFFF_FFFF_FFFF);
    // R7: negative dividend
    drive(1'b1, 15'(BIAS+10), 64'hB000_0000_0000_0003, 15'(BIAS+1), 64'hC000_0000_0000_0000);
    // R4 largest full gap, R5 smallest and a large partial gap
    drive(1'b0, 15'(BIAS+63), 64'hFFFF_FFFF_FFFF_FFFF, 15'(BIAS), 64'h8000_0000_0000_0003);
    drive(1'b0, 15'(BIAS+64), 64'hFFFF_FFFF_FFFF_FFFF, 15'(BIAS), 64'h8000_0000_0000_0003);
    drive(1'b1, 15'(BIAS+100), 64'h9234_5678_9ABC_DEF1, 15'(BIAS), 64'hD555_5555_5555_5555);
    // R1: a start while busy is ignored
    drive(1'b0, 15'(BIAS+20), 64'hF0F0_F0F0_F0F0_F0F1, 15'(BIAS), 64'h8765_4321_0FED_CBA9, 0);
    repeat (3) @(negedge clk);
    a_exp = 15'(BIAS-9); a_man = 64'h8000_0000_0000_0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    repeat (8) @(negedge clk);
    // R2: results hold while idle
    chk("R2 hold man", 80'(rem_man), 80'(last_e.man));
    chk("R2 hold exp", 80'(rem_exp), 80'(last_e.exp));
    chk("R2 hold q", 80'(q_lo), 80'(last_e.q));
    for (int i = 0; i < 24; i++) begin
      logic [63:0] x, y, z;
      int g, eb;
      x = rnd(); y = rnd(); z = rnd();
      g  = int'(z[7:0] % 80) - 4;
      eb = BIAS - 40 + int'(z[15:8] % 64);
      drive(z[16], 15'(eb + g), {1'b1, x[62:0]}, 15'(eb), {1'b1, y[62:0]});
    end
    repeat (5) @(negedge clk);
    chk("R1 scoreboard drained", 80'(sb.size()), 80'(0));
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule